// File: doc/BRIEF.md
# Host Remote DMA Engine

This block moves bytes between a host-facing data port and a byte-wide local packet memory. Software programs a start address, a byte count and a small configuration through an 8-bit register port. It then writes a 3-bit command that starts a remote read (memory to host), a remote write (host to memory) or a ring fetch. A ring fetch reads the next stored frame on its own: it takes the address from the boundary page and the length from the frame's header. A command with its top bit set aborts whatever transfer is running.

Each memory access moves one byte and advances a current-address counter. The host data port carries either one byte in the low lane or a 16-bit word built from two consecutive memory bytes, and the lane order is selectable. When the remaining count reaches zero, a completion flag is raised and drives `done_irq`. In auto-remove mode the engine starts a ring fetch by itself whenever the boundary page differs from the receiver's current write page. At the end of each fetched frame it moves the boundary to the frame's next-page link.

Register map (4-bit register address): 0 command (write, bits 2:0) / busy in bit 0 (read); 1 and 2 start address low and high; 3 and 4 remaining count low and high (written only while idle, read back live); 5 configuration (bit 0 word mode, bit 1 swap lanes, bit 2 auto-remove); 6 ring first page; 7 ring end page (exclusive); 8 boundary page; 9 and 10 current address low and high (read only); 11 flags (bit 0 completion, write 1 to clear).

Top module: `rdma_engine`

## Requirements
- R1: After reset, busy, the completion flag, `done_irq`, the current address and the remaining count all read as zero, and neither `mem_re` nor `mem_we` is asserted.
- R2: Command code 000 is ignored and starts nothing. A read, write or ring-fetch command written while a transfer is running is ignored too, and that transfer continues unchanged.
- R3: Command 001 reads memory starting at the programmed start address. In byte mode each host word is `{8'h00, byte}`, the address rises by 1 and the count falls by 1 per byte. `host_rdata` stays stable while `host_rvalid` is high and `host_rready` is low.
- R4: In word mode each host word holds two consecutive bytes, so the address rises by 2 per word. Without the swap bit the lower-address byte sits in bits 7:0; with the swap bit it sits in bits 15:8.
- R5: In word mode, an odd final byte is delivered as a half word. That byte goes in the lane its address would occupy, and the other lane is zero.
- R6: Command 010 writes host data to memory from the start address, using the same lane rules as R4. For an odd final byte in word mode only that one byte is written. `mem_re` and `mem_we` are never both high.
- R7: When the remaining count reaches zero, flag bit 0 and `done_irq` rise. A command issued with a zero count completes at once. Writing 1 to flag bit 0 clears it.
- R8: A command with bit 2 set stops the transfer on the next cycle. The current address keeps its value and is not reset to the start address. The remaining count reads 0, and the completion flag is not set.
- R9: The current address can be read while a transfer is in progress, and it shows the next memory byte to be accessed.
- R10: Command 011 reads a 4-byte header at offset 0 of the boundary page. Byte 1 is the next page, and bytes 2 (low) and 3 (high) are the frame length including the header. The engine then delivers that many bytes starting at offset 0 of the boundary page, and on completion the boundary becomes the next page.
- R11: During a ring fetch, an address that would step onto offset 0 of the ring end page goes instead to offset 0 of the ring first page.
- R12: With auto-remove set and the engine idle, a ring fetch starts without a command whenever the boundary page differs from `ring_wr_page`. No fetch starts while the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ring_wr_page | input | 8 | Page the receiver will write next |
| host_wdata | input | 16 | Host data toward memory |
| host_wvalid | input | 1 | Host write data valid |
| host_wready | output | 1 | Engine accepts host write data |
| host_rdata | output | 16 | Data toward the host |
| host_rvalid | output | 1 | Read data valid |
| host_rready | input | 1 | Host accepts read data |
| mem_addr | output | 16 | Local memory byte address |
| mem_re | output | 1 | Memory read; data returns on the next cycle |
| mem_we | output | 1 | Memory write |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| done_irq | output | 1 | Completion flag |

## Verification
Reads are run in byte mode, in word mode with an even count, in word mode with the swap bit set and an odd count, and with a single-byte word-mode count. Together these separate lane placement, stepping by one or two, and half-word handling. Writes are run in byte mode and in swapped word mode with an odd count, and a check that the byte after the last one is left untouched confirms the count is honoured. A ring fetch whose length is longer than the space left before the ring end shows the wrap, the header parsing and the boundary update. A stalled read that is disturbed by an illegal command and then aborted shows the live address readback and the abort side effects. An auto-remove pass, run first with equal pages and then with different ones, shows the self-start.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int PAGE_OFS_W = 8;
    localparam int REG_AW     = 4;
    localparam int CMD_W      = 3;

    localparam logic [REG_AW-1:0] RA_CMD     = 4'd0;
    localparam logic [REG_AW-1:0] RA_START_L = 4'd1;
    localparam logic [REG_AW-1:0] RA_START_H = 4'd2;
    localparam logic [REG_AW-1:0] RA_CNT_L   = 4'd3;
    localparam logic [REG_AW-1:0] RA_CNT_H   = 4'd4;
    localparam logic [REG_AW-1:0] RA_CFG     = 4'd5;
    localparam logic [REG_AW-1:0] RA_RFIRST  = 4'd6;
    localparam logic [REG_AW-1:0] RA_REND    = 4'd7;
    localparam logic [REG_AW-1:0] RA_BND     = 4'd8;
    localparam logic [REG_AW-1:0] RA_CUR_L   = 4'd9;
    localparam logic [REG_AW-1:0] RA_CUR_H   = 4'd10;
    localparam logic [REG_AW-1:0] RA_FLAGS   = 4'd11;

    localparam logic [CMD_W-1:0] CMD_READ  = 3'b001;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'b010;
    localparam logic [CMD_W-1:0] CMD_RING  = 3'b011;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HFETCH, ST_HCAP, ST_RFETCH, ST_RCAP, ST_ROUT, ST_WIN, ST_WMEM
    } rdma_state_t;

    typedef struct packed {
        logic auto_rm;
        logic swap;
        logic word;
    } rdma_cfg_t;

    function automatic logic cmd_is_abort(input logic [CMD_W-1:0] c);
        return c[CMD_W-1];
    endfunction
endpackage

// File: rtl/rdma_addr_step.sv
module rdma_addr_step #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wrap_en,
    input  logic [PAGE_W-1:0] ring_first,
    input  logic [PAGE_W-1:0] ring_end,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] plus_one;
    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W-1:0] first_addr;

    assign plus_one   = cur + ADDR_W'(1);
    assign end_addr   = {ring_end, {OFS_W{1'b0}}};
    assign first_addr = {ring_first, {OFS_W{1'b0}}};
    assign nxt        = (wrap_en && plus_one == end_addr) ? first_addr : plus_one;
endmodule

// File: rtl/rdma_regfile.sv
module rdma_regfile import rdma_pkg::*; #(
    parameter int ADDR_W = 16,
    localparam int PAGE_W = ADDR_W - PAGE_OFS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [ADDR_W-1:0]   cur,
    input  logic [ADDR_W-1:0]   cnt,
    input  logic [PAGE_W-1:0]   bnd,
    output logic [ADDR_W-1:0]   start_addr,
    output rdma_cfg_t           cfg,
    output logic [PAGE_W-1:0]   ring_first,
    output logic [PAGE_W-1:0]   ring_end,
    output logic                cmd_stb,
    output logic                cnt_lo_stb,
    output logic                cnt_hi_stb,
    output logic                bnd_stb,
    output logic                done_clr
);
    logic [ADDR_W-1:0] start_q;
    rdma_cfg_t         cfg_q;
    logic [PAGE_W-1:0] first_q, end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cfg_q   <= '0;
            first_q <= '0;
            end_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_START_L: start_q[BYTE_W-1:0]      <= reg_wdata;
                RA_START_H: start_q[ADDR_W-1:BYTE_W] <= reg_wdata;
                RA_CFG:     cfg_q   <= reg_wdata[2:0];
                RA_RFIRST:  first_q <= reg_wdata;
                RA_REND:    end_q   <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign start_addr = start_q;
    assign cfg        = cfg_q;
    assign ring_first = first_q;
    assign ring_end   = end_q;

    assign cmd_stb    = reg_wr && reg_addr == RA_CMD;
    assign cnt_lo_stb = reg_wr && reg_addr == RA_CNT_L;
    assign cnt_hi_stb = reg_wr && reg_addr == RA_CNT_H;
    assign bnd_stb    = reg_wr && reg_addr == RA_BND;
    assign done_clr   = reg_wr && reg_addr == RA_FLAGS && reg_wdata[0];

    always_comb begin
        case (reg_addr)
            RA_CMD:     reg_rdata = {7'b0, busy};
            RA_START_L: reg_rdata = start_q[BYTE_W-1:0];
            RA_START_H: reg_rdata = start_q[ADDR_W-1:BYTE_W];
            RA_CNT_L:   reg_rdata = cnt[BYTE_W-1:0];
            RA_CNT_H:   reg_rdata = cnt[ADDR_W-1:BYTE_W];
            RA_CFG:     reg_rdata = {5'b0, cfg_q};
            RA_RFIRST:  reg_rdata = first_q;
            RA_REND:    reg_rdata = end_q;
            RA_BND:     reg_rdata = bnd;
            RA_CUR_L:   reg_rdata = cur[BYTE_W-1:0];
            RA_CUR_H:   reg_rdata = cur[ADDR_W-1:BYTE_W];
            RA_FLAGS:   reg_rdata = {7'b0, done};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl import rdma_pkg::*; #(
    parameter int ADDR_W = 16,
    localparam int PAGE_W = ADDR_W - PAGE_OFS_W,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_stb,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                cnt_lo_stb,
    input  logic                cnt_hi_stb,
    input  logic                bnd_stb,
    input  logic                done_clr,
    input  rdma_cfg_t           cfg,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [PAGE_W-1:0]   ring_first,
    input  logic [PAGE_W-1:0]   ring_end,
    input  logic [PAGE_W-1:0]   ring_wr_page,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_wvalid,
    output logic                host_wready,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    input  logic                host_rready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_re,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   cur,
    output logic [ADDR_W-1:0]   cnt,
    output logic [PAGE_W-1:0]   bnd,
    output logic                done,
    output logic                busy
);
    rdma_state_t              st_q;
    logic [ADDR_W-1:0]        cur_q, cur_nxt, cnt_q;
    logic [PAGE_W-1:0]        bnd_q, nxt_pg_q;
    logic [1:0]               hidx_q;
    logic                     lane_q;
    logic [1:0][BYTE_W-1:0]   buf_q;
    logic                     ring_q, done_q;
    logic                     abort, idle, go_read, go_write, go_ring, fin;
    logic [CMD_W-1:0]         code;

    rdma_addr_step #(.ADDR_W(ADDR_W), .OFS_W(PAGE_OFS_W)) u_step (
        .cur(cur_q), .wrap_en(ring_q), .ring_first(ring_first),
        .ring_end(ring_end), .nxt(cur_nxt)
    );

    assign code     = wdata[CMD_W-1:0];
    assign idle     = st_q == ST_IDLE;
    assign abort    = cmd_stb && cmd_is_abort(code);
    assign go_read  = idle && cmd_stb && code == CMD_READ;
    assign go_write = idle && cmd_stb && code == CMD_WRITE;
    assign go_ring  = idle && ((cmd_stb && code == CMD_RING) ||
                               (!cmd_stb && cfg.auto_rm && bnd_q != ring_wr_page));

    always_comb begin
        fin = 1'b0;
        case (st_q)
            ST_IDLE: fin = (go_read || go_write) && cnt_q == '0;
            ST_HCAP: fin = hidx_q == 2'd3 && {mem_rdata, cnt_q[BYTE_W-1:0]} == '0;
            ST_ROUT: fin = host_rready && cnt_q == '0;
            ST_WMEM: fin = cnt_q == ADDR_W'(1);
            default: fin = 1'b0;
        endcase
        if (abort) fin = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            cnt_q    <= '0;
            bnd_q    <= '0;
            nxt_pg_q <= '0;
            hidx_q   <= '0;
            lane_q   <= 1'b0;
            buf_q    <= '0;
            ring_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            if (bnd_stb) bnd_q <= wdata;
            if (idle && cnt_lo_stb) cnt_q[BYTE_W-1:0]      <= wdata;
            if (idle && cnt_hi_stb) cnt_q[ADDR_W-1:BYTE_W] <= wdata;
            if (abort) begin
                st_q   <= ST_IDLE;
                cnt_q  <= '0;
                ring_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        lane_q <= 1'b0;
                        buf_q  <= '0;
                        if (go_read) begin
                            cur_q <= start_addr;
                            st_q  <= ST_RFETCH;
                        end else if (go_write) begin
                            cur_q <= start_addr;
                            st_q  <= ST_WIN;
                        end else if (go_ring) begin
                            hidx_q <= '0;
                            ring_q <= 1'b1;
                            st_q   <= ST_HFETCH;
                        end
                    end
                    ST_HFETCH: st_q <= ST_HCAP;
                    ST_HCAP: begin
                        case (hidx_q)
                            2'd1: nxt_pg_q <= mem_rdata;
                            2'd2: cnt_q[BYTE_W-1:0] <= mem_rdata;
                            2'd3: cnt_q[ADDR_W-1:BYTE_W] <= mem_rdata;
                            default: ;
                        endcase
                        if (hidx_q == 2'd3) begin
                            cur_q <= {bnd_q, {PAGE_OFS_W{1'b0}}};
                            st_q  <= ST_RFETCH;
                        end else begin
                            hidx_q <= hidx_q + 2'd1;
                            st_q   <= ST_HFETCH;
                        end
                    end
                    ST_RFETCH: st_q <= ST_RCAP;
                    ST_RCAP: begin
                        buf_q[lane_q] <= mem_rdata;
                        cur_q <= cur_nxt;
                        cnt_q <= cnt_q - ADDR_W'(1);
                        if (cfg.word && !lane_q && cnt_q != ADDR_W'(1)) begin
                            lane_q <= 1'b1;
                            st_q   <= ST_RFETCH;
                        end else begin
                            st_q <= ST_ROUT;
                        end
                    end
                    ST_ROUT: begin
                        if (host_rready) begin
                            lane_q <= 1'b0;
                            buf_q  <= '0;
                            st_q   <= ST_RFETCH;
                        end
                    end
                    ST_WIN: begin
                        if (host_wvalid) begin
                            lane_q <= 1'b0;
                            if (cfg.word && cfg.swap)
                                buf_q <= {host_wdata[BYTE_W-1:0], host_wdata[DATA_W-1:BYTE_W]};
                            else
                                buf_q <= {host_wdata[DATA_W-1:BYTE_W], host_wdata[BYTE_W-1:0]};
                            st_q <= ST_WMEM;
                        end
                    end
                    ST_WMEM: begin
                        cur_q <= cur_nxt;
                        cnt_q <= cnt_q - ADDR_W'(1);
                        if (cfg.word && !lane_q) lane_q <= 1'b1;
                        else st_q <= ST_WIN;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
            if (fin) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
                if (ring_q) begin
                    bnd_q  <= nxt_pg_q;
                    ring_q <= 1'b0;
                end
            end
        end
    end

    assign mem_re      = st_q == ST_HFETCH || st_q == ST_RFETCH;
    assign mem_we      = st_q == ST_WMEM;
    assign mem_addr    = (st_q == ST_HFETCH) ?
                         {bnd_q, {(PAGE_OFS_W-2){1'b0}}, hidx_q} : cur_q;
    assign mem_wdata   = buf_q[lane_q];
    assign host_wready = st_q == ST_WIN;
    assign host_rvalid = st_q == ST_ROUT;
    assign host_rdata  = !cfg.word ? {{BYTE_W{1'b0}}, buf_q[0]} :
                         cfg.swap  ? {buf_q[0], buf_q[1]} : {buf_q[1], buf_q[0]};

    assign cur  = cur_q;
    assign cnt  = cnt_q;
    assign bnd  = bnd_q;
    assign done = done_q;
    assign busy = !idle;
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine import rdma_pkg::*; #(
    parameter int ADDR_W = rdma_pkg::ADDR_W,
    localparam int PAGE_W = ADDR_W - PAGE_OFS_W,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [PAGE_W-1:0] ring_wr_page,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wvalid,
    output logic              host_wready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              host_rready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              done_irq
);
    rdma_cfg_t         cfg_w;
    logic [ADDR_W-1:0] start_w, cur_w, cnt_w;
    logic [PAGE_W-1:0] first_w, end_w, bnd_w;
    logic              cmd_stb_w, cnt_lo_w, cnt_hi_w, bnd_stb_w, clr_w;
    logic              busy_w, done_w, auto_en_w;

    assign auto_en_w = cfg_w.auto_rm;

    rdma_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .done(done_w), .cur(cur_w), .cnt(cnt_w), .bnd(bnd_w),
        .start_addr(start_w), .cfg(cfg_w), .ring_first(first_w), .ring_end(end_w),
        .cmd_stb(cmd_stb_w), .cnt_lo_stb(cnt_lo_w), .cnt_hi_stb(cnt_hi_w),
        .bnd_stb(bnd_stb_w), .done_clr(clr_w)
    );

    rdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb_w), .wdata(reg_wdata),
        .cnt_lo_stb(cnt_lo_w), .cnt_hi_stb(cnt_hi_w), .bnd_stb(bnd_stb_w),
        .done_clr(clr_w), .cfg(cfg_w), .start_addr(start_w),
        .ring_first(first_w), .ring_end(end_w), .ring_wr_page(ring_wr_page),
        .host_wdata(host_wdata), .host_wvalid(host_wvalid), .host_wready(host_wready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rready(host_rready),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cur(cur_w), .cnt(cnt_w), .bnd(bnd_w), .done(done_w), .busy(busy_w)
    );

    assign done_irq = done_w;
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              busy,
    input logic              auto_en,
    input logic              done_irq,
    input logic [ADDR_W-1:0] live_cnt,
    input logic              host_rvalid,
    input logic              host_rready,
    input logic [15:0]       host_rdata,
    input logic              mem_re,
    input logic              mem_we
);
    logic abort_wr;
    assign abort_wr = reg_wr && reg_addr == 4'd0 && reg_wdata[2];

    assert_mem_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        host_rvalid && !host_rready && !abort_wr |=> host_rvalid && $stable(host_rdata));

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        abort_wr |=> !busy && !host_rvalid && !mem_re && !mem_we && live_cnt == '0);

    assert_done_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_irq) |-> live_cnt == '0);

    assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == 4'd0 && reg_wdata[2:0] == 3'b000 && !busy && !auto_en
        |=> !busy);
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy_w), .auto_en(auto_en_w),
    .done_irq(done_irq), .live_cnt(cnt_w), .host_rvalid(host_rvalid),
    .host_rready(host_rready), .host_rdata(host_rdata),
    .mem_re(mem_re), .mem_we(mem_we)
);

// File: tb/rdma_engine_tb_top.sv
module rdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  ring_wr_page = '0;
    logic [15:0] host_wdata = '0;
    logic        host_wvalid = 1'b0;
    logic        host_wready;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        host_rready = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        done_irq;

    logic [7:0]  mem [0:MEM_BYTES-1];
    int          n_chk = 0;
    int          n_err = 0;
    bit          ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    rdma_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ring_wr_page(ring_wr_page),
        .host_wdata(host_wdata), .host_wvalid(host_wvalid), .host_wready(host_wready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rready(host_rready),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_irq(done_irq)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_addr16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd_reg(lo, l);
        rd_reg(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic host_get(output logic [15:0] d);
        d = 16'hDEAD;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (host_rvalid) begin
                d = host_rdata;
                host_rready = 1'b1;
                @(negedge clk);
                host_rready = 1'b0;
                return;
            end
        end
    endtask

    task automatic host_put(input logic [15:0] d);
        @(negedge clk);
        host_wvalid = 1'b1; host_wdata = d;
        for (int i = 0; i < 200; i++) begin
            if (host_wready) begin
                @(negedge clk);
                host_wvalid = 1'b0;
                return;
            end
            @(negedge clk);
        end
        host_wvalid = 1'b0;
    endtask

    task automatic setup(input logic [15:0] start, input logic [15:0] count, input logic [7:0] cfg);
        wr_reg(4'd1, start[7:0]);
        wr_reg(4'd2, start[15:8]);
        wr_reg(4'd3, count[7:0]);
        wr_reg(4'd4, count[15:8]);
        wr_reg(4'd5, cfg);
        wr_reg(4'd11, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        logic [15:0] v;
        rd_reg(4'd0, r);     chk("R1 busy", {8'h0, r}, 16'h0);
        rd_reg(4'd11, r);    chk("R1 flags", {8'h0, r}, 16'h0);
        rd_addr16(4'd9, v);  chk("R1 cur", v, 16'h0);
        rd_addr16(4'd3, v);  chk("R1 count", v, 16'h0);
        chk("R1 irq", {15'h0, done_irq}, 16'h0);
        chk("R1 mem idle", {14'h0, mem_re, mem_we}, 16'h0);
    endtask

    task automatic t_illegal();
        logic [7:0] r;
        logic [15:0] v;
        setup(16'h0010, 16'd5, 8'h00);
        wr_reg(4'd0, 8'h00);
        repeat (5) @(negedge clk);
        rd_reg(4'd0, r);     chk("R2 illegal busy", {8'h0, r}, 16'h0);
        rd_addr16(4'd9, v);  chk("R2 illegal cur", v, 16'h0);
        rd_addr16(4'd3, v);  chk("R2 illegal count", v, 16'd5);
    endtask

    task automatic t_byte_read();
        logic [15:0] d, v;
        logic [7:0] r;
        setup(16'h0020, 16'd3, 8'h00);
        wr_reg(4'd0, 8'h01);
        for (int k = 0; k < 3; k++) begin
            host_get(d);
            chk("R3 byte read", d, {8'h00, mem[16'h20 + k]});
        end
        repeat (3) @(negedge clk);
        rd_addr16(4'd9, v);  chk("R3 cur after", v, 16'h0023);
        rd_reg(4'd11, r);    chk("R7 flag", {8'h0, r}, 16'h1);
        chk("R7 irq", {15'h0, done_irq}, 16'h1);
        wr_reg(4'd11, 8'h01);
        chk("R7 irq cleared", {15'h0, done_irq}, 16'h0);
    endtask

    task automatic t_word_read();
        logic [15:0] d, v;
        setup(16'h0040, 16'd4, 8'h01);
        wr_reg(4'd0, 8'h01);
        host_get(d); chk("R4 word lo-first", d, {mem[16'h41], mem[16'h40]});
        host_get(d); chk("R4 word second", d, {mem[16'h43], mem[16'h42]});
        repeat (3) @(negedge clk);
        rd_addr16(4'd9, v); chk("R4 cur step 2", v, 16'h0044);
        setup(16'h0050, 16'd3, 8'h03);
        wr_reg(4'd0, 8'h01);
        host_get(d); chk("R4 swapped word", d, {mem[16'h50], mem[16'h51]});
        host_get(d); chk("R5 odd swapped", d, {mem[16'h52], 8'h00});
        setup(16'h0061, 16'd1, 8'h01);
        wr_reg(4'd0, 8'h01);
        host_get(d); chk("R5 odd plain", d, {8'h00, mem[16'h61]});
    endtask

    task automatic t_write();
        logic [7:0] keep;
        setup(16'h0100, 16'd2, 8'h00);
        wr_reg(4'd0, 8'h02);
        host_put(16'h77AA);
        host_put(16'h66BB);
        repeat (3) @(negedge clk);
        chk("R6 byte write 0", {8'h0, mem[16'h100]}, 16'h00AA);
        chk("R6 byte write 1", {8'h0, mem[16'h101]}, 16'h00BB);
        keep = mem[16'h113];
        setup(16'h0110, 16'd3, 8'h03);
        wr_reg(4'd0, 8'h02);
        host_put(16'h1234);
        host_put(16'h5678);
        repeat (3) @(negedge clk);
        chk("R6 swap write 0", {8'h0, mem[16'h110]}, 16'h0012);
        chk("R6 swap write 1", {8'h0, mem[16'h111]}, 16'h0034);
        chk("R6 odd write", {8'h0, mem[16'h112]}, 16'h0056);
        chk("R6 beyond count", {8'h0, mem[16'h113]}, {8'h0, keep});
        chk("R7 write done", {15'h0, done_irq}, 16'h1);
    endtask

    task automatic t_zero_count();
        logic [7:0] r;
        logic [15:0] v;
        setup(16'h0080, 16'd0, 8'h00);
        wr_reg(4'd0, 8'h01);
        repeat (2) @(negedge clk);
        rd_reg(4'd11, r);    chk("R7 zero count done", {8'h0, r}, 16'h1);
        rd_reg(4'd0, r);     chk("R7 zero count idle", {8'h0, r}, 16'h0);
        rd_addr16(4'd9, v);  chk("R7 zero count cur", v, 16'h0080);
    endtask

    task automatic t_abort();
        logic [15:0] d, v;
        logic [7:0] r;
        setup(16'h0200, 16'd10, 8'h00);
        wr_reg(4'd0, 8'h01);
        host_get(d); chk("R3 abort pre byte0", d, {8'h00, mem[16'h200]});
        repeat (4) @(negedge clk);
        rd_addr16(4'd9, v);  chk("R9 live cur", v, 16'h0202);
        rd_reg(4'd0, r);     chk("R9 busy during", {8'h0, r}, 16'h1);
        wr_reg(4'd0, 8'h02);
        host_get(d); chk("R2 busy cmd ignored", d, {8'h00, mem[16'h201]});
        repeat (4) @(negedge clk);
        wr_reg(4'd0, 8'h04);
        repeat (2) @(negedge clk);
        rd_addr16(4'd9, v);  chk("R8 cur kept", v, 16'h0203);
        rd_addr16(4'd3, v);  chk("R8 count cleared", v, 16'h0);
        rd_reg(4'd11, r);    chk("R8 no done", {8'h0, r}, 16'h0);
        rd_reg(4'd0, r);     chk("R8 idle", {8'h0, r}, 16'h0);
        chk("R8 no rvalid", {15'h0, host_rvalid}, 16'h0);
    endtask

    task automatic t_ring();
        logic [15:0] d, v, a;
        logic [7:0] exp_b [0:259];
        logic [7:0] r;
        mem[16'h300] = 8'h01; mem[16'h301] = 8'h02;
        mem[16'h302] = 8'h04; mem[16'h303] = 8'h01;
        a = 16'h0300;
        for (int k = 0; k < 260; k++) begin
            exp_b[k] = mem[a[9:0]];
            a = a + 16'd1;
            if (a == 16'h0400) a = 16'h0100;
        end
        wr_reg(4'd6, 8'h01);
        wr_reg(4'd7, 8'h04);
        wr_reg(4'd8, 8'h03);
        setup(16'h0000, 16'd0, 8'h01);
        wr_reg(4'd0, 8'h03);
        host_get(d); chk("R10 header word", d, 16'h0201);
        for (int k = 1; k < 130; k++) begin
            host_get(d);
            chk("R11 ring word", d, {exp_b[2*k+1], exp_b[2*k]});
        end
        repeat (3) @(negedge clk);
        rd_addr16(4'd9, v);  chk("R11 wrapped cur", v, 16'h0104);
        rd_reg(4'd8, r);     chk("R10 boundary moved", {8'h0, r}, 16'h0002);
        rd_reg(4'd11, r);    chk("R10 done", {8'h0, r}, 16'h1);
    endtask

    task automatic t_auto();
        logic [15:0] d;
        logic [7:0] r;
        mem[16'h200] = 8'h01; mem[16'h201] = 8'h03;
        mem[16'h202] = 8'h05; mem[16'h203] = 8'h00;
        @(negedge clk);
        ring_wr_page = 8'h02;
        setup(16'h0000, 16'd0, 8'h04);
        repeat (5) @(negedge clk);
        rd_reg(4'd0, r);     chk("R12 no start when equal", {8'h0, r}, 16'h0);
        @(negedge clk);
        ring_wr_page = 8'h03;
        for (int k = 0; k < 5; k++) begin
            host_get(d);
            chk("R12 auto byte", d, {8'h00, mem[16'h200 + k]});
        end
        repeat (3) @(negedge clk);
        rd_reg(4'd8, r);     chk("R12 boundary advanced", {8'h0, r}, 16'h0003);
        rd_reg(4'd11, r);    chk("R12 done", {8'h0, r}, 16'h1);
        rd_reg(4'd0, r);     chk("R12 idle after", {8'h0, r}, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_illegal();
        t_byte_read();
        t_word_read();
        t_write();
        t_zero_count();
        t_abort();
        t_ring();
        t_auto();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule